// File: doc/BRIEF.md
# Multiplexed LCD drive-level sequencer

This block decides, for every pin of a segment LCD with up to three backplanes and 32 segment lines, which drive level the pin carries in each time slot. Every pin gets a 3-bit level code. The analog bias divider and the pad buffers turn that code into a voltage. A single flag tells the buffers to float every pin. A two-pin mode select chooses how many backplanes are in use and the bias scheme. A 96-bit display image comes in from an external serial shift register. It is copied into an internal display latch only at half-frame boundaries, and only while the serial load enable is low.

Frame timing comes from an oscillator-rate clock enable. One frame spans `FRAME_TICKS` enable pulses (2400 by default). It is split into one slot per active backplane, and then the same slots are repeated with inverted polarity so the LCD sees no net DC. After reset the block is in power-down: every pin floats and no timing runs. It stays there until the first rising edge of the serial clock, which reaches the block as a one-cycle wake pulse.

Top module: `lcdseq_drive`

## Requirements
- R1: The mode code on `mode_sel` is read as follows:
  - 01 is static drive with one backplane.
  - 10 is 1:2 multiplex with two backplanes.
  - 11 is 1:3 multiplex with three backplanes.
  - 00 is a test code. Once awake it drives every backplane and segment level to 0 (VSS), does not float the pins, and stops the slot timing.
- R2: Level codes are 0 = VSS, 1 = one-third, 2 = half, 3 = two-thirds and 4 = full VLCD. Backplane k sits at `bp_level[3k+2:3k]` and segment i at `seg_level[3i+2:3i]`. In static mode:
  - the first backplane is 4 in the first half frame and 0 in the second;
  - backplanes two and three stay at 0;
  - an off segment copies the first backplane and an on segment drives the other rail.
- R3: In 1:2 mode a frame is four equal slots: backplane one selected, backplane two selected, then both again with inverted polarity.
  - The selected backplane is 4 in the positive half and 0 in the inverted half.
  - The unselected one of the first two is 2, and the third backplane is always 2.
  - An on segment drives the rail opposite the selected backplane, and an off segment drives 2.
- R4: In 1:3 mode a frame is six equal slots, one per backplane and then repeated with inverted polarity.
  - The selected backplane is 4 or 0 as in R3.
  - The others are 1 in the positive half and 3 in the inverted half.
  - An on segment drives the opposite rail, and an off segment drives 3 in the positive half and 1 in the inverted half.
- R5: Segment i (0..31) is on when its latch bit is 1. It uses latch bit i during the first backplane's slot, bit 32+i during the second and bit 64+i during the third.
- R6: One frame is exactly 2400 `osc_tick` pulses. Each slot lasts 2400/(2×backplanes) pulses. Clock cycles without a pulse do not advance the timing.
- R7: The latch copies `shift_image` only at the clock edge whose pulse completes a half frame, and only if `load_en` is low in that cycle. While `load_en` is high the latch holds, including when the rise of `load_en` coincides with a boundary.
- R8: After reset all level codes are 0, the float flag is set, the latch is cleared and the mode register holds the test code.
- R9: After reset the block is in power-down: `pads_hiz` is 1, all level codes are 0 and the timing is frozen whatever `osc_tick` does. A `wake_pulse` clears `pads_hiz` at the following edge, and timing starts with the next pulse.
- R10: A change on `mode_sel` restarts the timing at slot 0 in positive polarity at the next edge. No latch load happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator-rate clock enable |
| wake_pulse | input | 1 | One-cycle pulse on the first serial clock rise; ends power-down |
| mode_sel | input | 2 | Drive mode code (R1) |
| load_en | input | 1 | Serial load enable; latch holds while high |
| shift_image | input | 96 | Parallel view of the serial shift register |
| pads_hiz | output | 1 | All pins floating (power-down) |
| bp_level | output | 9 | Level codes for the three backplanes |
| seg_level | output | 96 | Level codes for the 32 segments |

## Verification
The half-frame latch strobe can fall in the same cycle as a rising load enable, or in the same cycle as a change of mode code. The bench runs the timing until the pulse that will complete a half frame is next. In that cycle it raises `load_en` and presents a new image. It then checks that the next full half frame still shows the old image. A mode change in the middle of a frame is judged the same way, against a reference that restarts the slot count and skips the load in that cycle.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    typedef enum logic [2:0] {
        LVL_VSS   = 3'd0,
        LVL_THIRD = 3'd1,
        LVL_HALF  = 3'd2,
        LVL_TWO3  = 3'd3,
        LVL_FULL  = 3'd4
    } level_e;

    typedef enum logic [1:0] {
        MODE_TEST    = 2'd0,
        MODE_STATIC  = 2'd1,
        MODE_DUPLEX  = 2'd2,
        MODE_TRIPLEX = 2'd3
    } mode_e;

    localparam int unsigned NUM_BP = 3;
    localparam int unsigned LVL_W  = 3;

endpackage

// File: rtl/lcdseq_timing.sv
module lcdseq_timing
    import lcdseq_pkg::*;
#(
    parameter int unsigned FRAME_TICKS = 2400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       wake,
    input  mode_e      mode_in,
    output mode_e      mode_q,
    output logic       awake_q,
    output logic [1:0] phase_q,
    output logic       pol_q,
    output logic       strobe
);

    localparam int unsigned LEN_STATIC  = FRAME_TICKS / 2;
    localparam int unsigned LEN_DUPLEX  = FRAME_TICKS / 4;
    localparam int unsigned LEN_TRIPLEX = FRAME_TICKS / 6;
    localparam int unsigned CNT_W       = $clog2(LEN_STATIC);

    typedef struct packed {
        mode_e            mode;
        logic             awake;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       phase;
        logic             pol;
    } tstate_t;

    tstate_t          st_d, st_q;
    logic [CNT_W-1:0] slot_last;
    logic [1:0]       phase_last;

    always_comb begin
        st_d   = st_q;
        strobe = 1'b0;
        case (st_q.mode)
            MODE_STATIC: begin
                slot_last  = CNT_W'(LEN_STATIC - 1);
                phase_last = 2'd0;
            end
            MODE_DUPLEX: begin
                slot_last  = CNT_W'(LEN_DUPLEX - 1);
                phase_last = 2'd1;
            end
            default: begin
                slot_last  = CNT_W'(LEN_TRIPLEX - 1);
                phase_last = 2'd2;
            end
        endcase
        if (mode_in != st_q.mode) begin
            st_d.mode  = mode_in;
            st_d.cnt   = '0;
            st_d.phase = '0;
            st_d.pol   = 1'b0;
        end else if (st_q.awake && st_q.mode != MODE_TEST && osc_tick) begin
            if (st_q.cnt == slot_last) begin
                st_d.cnt = '0;
                if (st_q.phase == phase_last) begin
                    st_d.phase = '0;
                    st_d.pol   = ~st_q.pol;
                    strobe     = 1'b1;
                end else begin
                    st_d.phase = st_q.phase + 2'd1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (wake) begin
            st_d.awake = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q  = st_q.mode;
    assign awake_q = st_q.awake;
    assign phase_q = st_q.phase;
    assign pol_q   = st_q.pol;

    assert_frozen_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.awake |=> (st_q.cnt == '0 && st_q.phase == '0 && !st_q.pol));

    assert_restart_on_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in != st_q.mode) |=> (st_q.cnt == '0 && st_q.phase == '0 && !st_q.pol));

    assert_test_mode_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_TEST && mode_in == MODE_TEST) |=> $stable(st_q.cnt));

    assert_phase_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= phase_last);

endmodule

// File: rtl/lcdseq_latch.sv
module lcdseq_latch #(
    parameter int unsigned WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             load_en,
    input  logic [WIDTH-1:0] image,
    output logic [WIDTH-1:0] latch_q
);

    logic [WIDTH-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        if (strobe && !load_en) begin
            latch_d = image;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    assert_hold_while_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> $stable(latch_q));

endmodule

// File: rtl/lcdseq_levels.sv
module lcdseq_levels
    import lcdseq_pkg::*;
#(
    parameter int unsigned NUM_SEG = 32
) (
    input  mode_e                            mode,
    input  logic                             awake,
    input  logic [1:0]                       phase,
    input  logic                             pol,
    input  logic [NUM_BP*NUM_SEG-1:0]        latch,
    output logic [NUM_BP*LVL_W-1:0]          bp_lvl,
    output logic [NUM_SEG*LVL_W-1:0]         seg_lvl
);

    logic         active;
    logic [1:0]   nbp;
    logic [NUM_SEG-1:0] row;
    level_e       sel_lvl, nonsel_lvl, park_lvl, on_lvl, off_lvl;

    always_comb begin
        active  = awake && (mode != MODE_TEST);
        sel_lvl = pol ? LVL_VSS : LVL_FULL;
        on_lvl  = pol ? LVL_FULL : LVL_VSS;
        case (mode)
            MODE_STATIC: begin
                nbp        = 2'd1;
                nonsel_lvl = LVL_VSS;
                park_lvl   = LVL_VSS;
                off_lvl    = sel_lvl;
            end
            MODE_DUPLEX: begin
                nbp        = 2'd2;
                nonsel_lvl = LVL_HALF;
                park_lvl   = LVL_HALF;
                off_lvl    = LVL_HALF;
            end
            default: begin
                nbp        = 2'd3;
                nonsel_lvl = pol ? LVL_TWO3 : LVL_THIRD;
                park_lvl   = LVL_VSS;
                off_lvl    = pol ? LVL_THIRD : LVL_TWO3;
            end
        endcase
        case (phase)
            2'd0:    row = latch[NUM_SEG-1:0];
            2'd1:    row = latch[2*NUM_SEG-1:NUM_SEG];
            default: row = latch[3*NUM_SEG-1:2*NUM_SEG];
        endcase
    end

    for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
        always_comb begin
            if (!active) begin
                bp_lvl[k*LVL_W +: LVL_W] = LVL_VSS;
            end else if (2'(k) >= nbp) begin
                bp_lvl[k*LVL_W +: LVL_W] = park_lvl;
            end else if (2'(k) == phase) begin
                bp_lvl[k*LVL_W +: LVL_W] = sel_lvl;
            end else begin
                bp_lvl[k*LVL_W +: LVL_W] = nonsel_lvl;
            end
        end
    end

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        always_comb begin
            if (!active) begin
                seg_lvl[i*LVL_W +: LVL_W] = LVL_VSS;
            end else begin
                seg_lvl[i*LVL_W +: LVL_W] = row[i] ? on_lvl : off_lvl;
            end
        end
    end

endmodule

// File: rtl/lcdseq_drive.sv
module lcdseq_drive
    import lcdseq_pkg::*;
#(
    parameter int unsigned NUM_SEG     = 32,
    parameter int unsigned FRAME_TICKS = 2400
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       osc_tick,
    input  logic                       wake_pulse,
    input  logic [1:0]                 mode_sel,
    input  logic                       load_en,
    input  logic [NUM_BP*NUM_SEG-1:0]  shift_image,
    output logic                       pads_hiz,
    output logic [NUM_BP*LVL_W-1:0]    bp_level,
    output logic [NUM_SEG*LVL_W-1:0]   seg_level
);

    localparam int unsigned IMG_W = NUM_BP * NUM_SEG;

    mode_e             mode_q;
    logic              awake_q;
    logic [1:0]        phase_q;
    logic              pol_q;
    logic              strobe;
    logic [IMG_W-1:0]  latch_q;

    lcdseq_timing #(.FRAME_TICKS(FRAME_TICKS)) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .wake     (wake_pulse),
        .mode_in  (mode_e'(mode_sel)),
        .mode_q   (mode_q),
        .awake_q  (awake_q),
        .phase_q  (phase_q),
        .pol_q    (pol_q),
        .strobe   (strobe)
    );

    lcdseq_latch #(.WIDTH(IMG_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .load_en (load_en),
        .image   (shift_image),
        .latch_q (latch_q)
    );

    lcdseq_levels #(.NUM_SEG(NUM_SEG)) u_levels (
        .mode    (mode_q),
        .awake   (awake_q),
        .phase   (phase_q),
        .pol     (pol_q),
        .latch   (latch_q),
        .bp_lvl  (bp_level),
        .seg_lvl (seg_level)
    );

    assign pads_hiz = !awake_q;

    logic [NUM_BP-1:0] on_rail;
    always_comb begin
        for (int k = 0; k < NUM_BP; k++) begin
            on_rail[k] = (bp_level[k*LVL_W +: LVL_W] == LVL_FULL) ||
                         (bp_level[k*LVL_W +: LVL_W] == LVL_VSS);
        end
    end

    assert_float_at_vss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pads_hiz |-> (bp_level == '0 && seg_level == '0));

    assert_test_code_vss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TEST) |-> (bp_level == '0 && seg_level == '0));

    assert_one_rail_backplane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_q && (mode_q == MODE_DUPLEX || mode_q == MODE_TRIPLEX))
            |-> ($countones(on_rail) == 1));

endmodule

// File: tb/lcdseq_drive_test.sv
`timescale 1ns/1ps
module lcdseq_drive_test;

    localparam int FRAME = 2400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        wake_pulse = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        load_en = 1'b0;
    logic [95:0] shift_image = '0;
    logic        pads_hiz;
    logic [8:0]  bp_level;
    logic [95:0] seg_level;

    int    checks = 0;
    int    errors = 0;
    bit    half_rate = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R8";

    always #10 clk = ~clk;

    lcdseq_drive uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick    (osc_tick),
        .wake_pulse  (wake_pulse),
        .mode_sel    (mode_sel),
        .load_en     (load_en),
        .shift_image (shift_image),
        .pads_hiz    (pads_hiz),
        .bp_level    (bp_level),
        .seg_level   (seg_level)
    );

    // Reference model built from the requirements
    bit          m_awake;
    logic [1:0]  m_mode;
    int          m_j;
    logic [95:0] m_latch;

    function automatic int nbp_of(logic [1:0] m);
        return (m == 2'd1) ? 1 : (m == 2'd2) ? 2 : 3;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_awake = 1'b0; m_mode = 2'd0; m_j = 0; m_latch = '0;
        end else begin
            if (mode_sel != m_mode) begin
                m_mode = mode_sel;
                m_j = 0;
            end else if (m_awake && m_mode != 2'd0 && osc_tick) begin
                m_j = m_j + 1;
                if (m_j % (FRAME / 2) == 0 && !load_en) m_latch = shift_image;
                if (m_j == FRAME) m_j = 0;
            end
            if (wake_pulse) m_awake = 1'b1;
        end
    end

    function automatic logic [2:0] exp_bp(int k);
        int nb, len, slot, ph, pl;
        if (!m_awake || m_mode == 2'd0) return 3'd0;
        nb = nbp_of(m_mode); len = FRAME / (2 * nb);
        slot = m_j / len; ph = slot % nb; pl = slot / nb;
        if (k >= nb) return (m_mode == 2'd2) ? 3'd2 : 3'd0;
        if (k == ph) return pl ? 3'd0 : 3'd4;
        return (m_mode == 2'd2) ? 3'd2 : (pl ? 3'd3 : 3'd1);
    endfunction

    function automatic logic [2:0] exp_seg(int i);
        int nb, len, slot, ph, pl;
        if (!m_awake || m_mode == 2'd0) return 3'd0;
        nb = nbp_of(m_mode); len = FRAME / (2 * nb);
        slot = m_j / len; ph = slot % nb; pl = slot / nb;
        if (m_latch[ph * 32 + i]) return pl ? 3'd4 : 3'd0;
        case (m_mode)
            2'd1:    return pl ? 3'd0 : 3'd4;
            2'd2:    return 3'd2;
            default: return pl ? 3'd1 : 3'd3;
        endcase
    endfunction

    task automatic compare();
        logic [8:0]  eb;
        logic [95:0] es;
        logic        eh;
        eh = !m_awake;
        for (int k = 0; k < 3; k++) eb[3*k +: 3] = exp_bp(k);
        for (int i = 0; i < 32; i++) es[3*i +: 3] = exp_seg(i);
        checks++;
        if (pads_hiz !== eh || bp_level !== eb) begin
            errors++;
            $display("FAIL %s backplanes: actual hiz=%b bp=%h expected hiz=%b bp=%h",
                     cur_req, pads_hiz, bp_level, eh, eb);
        end
        checks++;
        if (seg_level !== es) begin
            errors++;
            $display("FAIL %s segments: actual %h expected %h", cur_req, seg_level, es);
        end
    endtask

    task automatic step(int n);
        for (int c = 0; c < n; c++) begin
            osc_tick = half_rate ? ~osc_tick : 1'b1;
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare();                       // R8 reset state
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        cur_req = "R9 asleep";           // timing frozen while powered down
        mode_sel = 2'd3;
        shift_image = {32'hA5C3_0F96, 32'h1234_5678, 32'hFFFF_0001};
        step(40);

        cur_req = "R1 R2 R5 R6 R7 R9 static";
        mode_sel = 2'd1;
        step(2);
        wake_pulse = 1'b1;
        step(1);
        wake_pulse = 1'b0;
        step(2 * FRAME);

        cur_req = "R3 R5 R7 R10 duplex";
        shift_image = {32'h0F0F_F0F0, 32'hDEAD_BEEF, 32'h8000_0003};
        mode_sel = 2'd2;
        step(2 * FRAME);

        cur_req = "R4 R5 R6 R10 triplex half-rate";
        half_rate = 1'b1;
        shift_image = {32'hC001_D00D, 32'h5555_AAAA, 32'h7E81_3CC3};
        mode_sel = 2'd3;
        step(4 * FRAME);
        half_rate = 1'b0;

        cur_req = "R7 hold while enabled";
        load_en = 1'b1;
        shift_image = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666};
        step(FRAME);
        load_en = 1'b0;
        step(FRAME / 2 + 150);

        cur_req = "R7 enable rises on boundary";
        while ((m_j % (FRAME / 2)) != (FRAME / 2 - 1)) step(1);
        load_en = 1'b1;
        shift_image = ~shift_image;
        step(FRAME / 2 + 5);
        load_en = 1'b0;
        step(FRAME / 2);

        cur_req = "R1 test code";
        mode_sel = 2'd0;
        step(300);

        cur_req = "R10 restart mid frame";
        mode_sel = 2'd2;
        step(777);
        mode_sel = 2'd3;
        step(FRAME + 10);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule